// File: doc/BRIEF.md
# LCD Panel Power-Save Sequencer

This block moves a simple LCD timing controller into and out of a low-power state. It decodes power-save requests from the host register write port. It then counts frame-boundary pulses from the panel timing generator to place entry on a frame edge. Blanking comes first and the row-driver disable follows. While asleep it stops the display clocks, holds the panel outputs low and tri-states the host data bus.

Wake-up is a handshake. After an exit request the block restores the clocks and the bus. It then absorbs a fixed number of dummy register writes before it reports ready and lifts blanking. That number depends on the addressing mode. The row-driver disable lifts on the first frame boundary after exit, whether or not the dummy writes are complete.

Top module: `lcd_pwrsave_seq`

## Requirements
- R1: After reset the block is running: `blank_o`=0, `ydis_o`=1, `clk_en_o`=1, `panel_hold_o`=0, `bus_hiz_o`=0, `ready_o`=1.
- R2: With `indirect_i`=0, a write to address 8 requests sleep when data bit 0 is 1 and requests exit when it is 0. With `indirect_i`=1, a write to address 1 with byte 0x53 requests sleep and byte 0x40 requests exit. Writes that match the other mode's form are ignored.
- R3: `blank_o` rises in the cycle after a sleep request while `ready_o` stays 1. The sleep state is entered in the cycle after the second `frame_i` pulse that follows the request cycle, and not after the first one.
- R4: In the sleep state `panel_hold_o`=1, `bus_hiz_o`=1, `clk_en_o`=0 and `ready_o`=0.
- R5: `ydis_o` falls in the same cycle that sleep is entered and stays low throughout sleep.
- R6: A further sleep request during entry is ignored and does not restart the frame count.
- R7: An exit request during entry returns the block to running in the next cycle. Later frame pulses do not resume the entry.
- R8: In sleep, `frame_i` pulses and all writes other than an exit request leave the outputs unchanged.
- R9: After an exit request from sleep, the next cycle shows `panel_hold_o`=0, `bus_hiz_o`=0, `clk_en_o`=1, `ready_o`=0 and `blank_o`=1.
- R10: After exit, every write counts as a dummy write whatever its address or data. The exit write itself is not counted. `ready_o` rises and `blank_o` falls in the cycle after the 1st dummy write in direct mode, or after the 2nd in indirect mode.
- R11: `ydis_o` returns to 1 in the cycle after the first `frame_i` pulse that follows the exit request, independent of the dummy-write progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| indirect_i | input | 1 | Addressing mode: 0 direct, 1 indirect |
| wr_en_i | input | 1 | Host register write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | DATA_W | Host write data |
| frame_i | input | 1 | Single-cycle frame-boundary pulse |
| blank_o | output | 1 | Force blank pixel data to column drivers |
| ydis_o | output | 1 | Row-driver disable, active low |
| clk_en_o | output | 1 | Enable for internal display clocks |
| panel_hold_o | output | 1 | Hold frame, line, shift, MOD and data pins low |
| bus_hiz_o | output | 1 | Tri-state host data bus and wait output |
| ready_o | output | 1 | Normal register operation available |

## Verification
The assertions assume that `frame_i` is a single-cycle pulse and that each host write raises `wr_en_i` for exactly one cycle. They also assume that `indirect_i` changes only while the block is running, because the dummy-write target is read during wake-up. The bench drives every input from tasks that produce one-cycle pulses. It changes the mode only between sweep passes, when the block is back in the running state. The sweep covers both modes, several request-to-frame gaps and aborts at each entry phase, and places a frame pulse before or after the dummy writes.

// File: rtl/lcd_ps_pkg.sv
package lcd_ps_pkg;
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_ARM   = 3'd1,  // blanking, waiting for first frame edge
    PS_BLANK = 3'd2,  // full blank frame in progress
    PS_SLEEP = 3'd3,
    PS_WAKE  = 3'd4   // awaiting dummy writes
  } ps_state_e;
endpackage

// File: rtl/lcd_ps_decode.sv
module lcd_ps_decode #(
  parameter int          ADDR_W     = 4,
  parameter int          DATA_W     = 8,
  parameter int          ENABLE_BIT = 0,
  parameter logic [3:0]  CTRL_ADDR  = 4'h8,
  parameter logic [3:0]  CMD_ADDR   = 4'h1,
  parameter logic [7:0]  SLEEP_CMD  = 8'h53,
  parameter logic [7:0]  SETUP_CMD  = 8'h40
) (
  input  logic              indirect_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              req_enter_o,
  output logic              req_exit_o
);
  logic dir_hit, ind_hit;

  assign dir_hit = wr_en_i && !indirect_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));
  assign ind_hit = wr_en_i &&  indirect_i && (wr_addr_i == ADDR_W'(CMD_ADDR));

  assign req_enter_o = (dir_hit && wr_data_i[ENABLE_BIT])
                     || (ind_hit && (wr_data_i == DATA_W'(SLEEP_CMD)));
  assign req_exit_o  = (dir_hit && !wr_data_i[ENABLE_BIT])
                     || (ind_hit && (wr_data_i == DATA_W'(SETUP_CMD)));
endmodule

// File: rtl/lcd_ps_wake_cnt.sv
module lcd_ps_wake_cnt #(
  parameter int DIRECT_WR   = 1,
  parameter int INDIRECT_WR = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic indirect_i,
  output logic done_o
);
  localparam int MAX_WR = (DIRECT_WR > INDIRECT_WR) ? DIRECT_WR : INDIRECT_WR;
  localparam int CNT_W  = $clog2(MAX_WR + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic [CNT_W:0]   cnt_nxt;

  assign need    = indirect_i ? CNT_W'(INDIRECT_WR) : CNT_W'(DIRECT_WR);
  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign done_o  = inc_i && (cnt_nxt >= {1'b0, need});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (inc_i)          cnt_q <= cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/lcd_ps_fsm.sv
module lcd_ps_fsm
  import lcd_ps_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_enter_i,
  input  logic      req_exit_i,
  input  logic      frame_i,
  input  logic      wake_done_i,
  output ps_state_e state_q_o,
  output ps_state_e state_d_o
);
  ps_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:   if (req_enter_i) state_d = PS_ARM;
      PS_ARM:   if (req_exit_i) state_d = PS_RUN;
                else if (frame_i) state_d = PS_BLANK;
      PS_BLANK: if (req_exit_i) state_d = PS_RUN;
                else if (frame_i) state_d = PS_SLEEP;
      PS_SLEEP: if (req_exit_i) state_d = PS_WAKE;
      PS_WAKE:  if (wake_done_i) state_d = PS_RUN;
      default:  state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_RUN;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/lcd_ps_pins.sv
module lcd_ps_pins
  import lcd_ps_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ps_state_e state_q_i,
  input  ps_state_e state_d_i,
  input  logic      frame_i,
  output logic      blank_o,
  output logic      ydis_o,
  output logic      clk_en_o,
  output logic      panel_hold_o,
  output logic      bus_hiz_o,
  output logic      ready_o
);
  logic ydis_q;
  logic asleep;

  // ydis kept apart from state: it may lift before wake-up ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ydis_q <= 1'b1;
    else if (state_d_i == PS_SLEEP && state_q_i != PS_SLEEP)
      ydis_q <= 1'b0;
    else if (frame_i && (state_q_i == PS_WAKE || state_q_i == PS_RUN))
      ydis_q <= 1'b1;
  end

  assign asleep       = (state_q_i == PS_SLEEP);
  assign blank_o      = (state_q_i != PS_RUN);
  assign ydis_o       = ydis_q;
  assign clk_en_o     = !asleep;
  assign panel_hold_o = asleep;
  assign bus_hiz_o    = asleep;
  assign ready_o      = (state_q_i == PS_RUN) || (state_q_i == PS_ARM)
                     || (state_q_i == PS_BLANK);
endmodule

// File: rtl/lcd_pwrsave_seq.sv
module lcd_pwrsave_seq
  import lcd_ps_pkg::*;
#(
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 8,
  parameter int         ENABLE_BIT  = 0,
  parameter logic [3:0] CTRL_ADDR   = 4'h8,
  parameter logic [3:0] CMD_ADDR    = 4'h1,
  parameter logic [7:0] SLEEP_CMD   = 8'h53,
  parameter logic [7:0] SETUP_CMD   = 8'h40,
  parameter int         DIRECT_WR   = 1,
  parameter int         INDIRECT_WR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              indirect_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_i,
  output logic              blank_o,
  output logic              ydis_o,
  output logic              clk_en_o,
  output logic              panel_hold_o,
  output logic              bus_hiz_o,
  output logic              ready_o
);
  logic      req_enter, req_exit, wake_done;
  ps_state_e state_q, state_d;

  lcd_ps_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENABLE_BIT(ENABLE_BIT),
    .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR),
    .SLEEP_CMD(SLEEP_CMD), .SETUP_CMD(SETUP_CMD)
  ) u_dec (
    .indirect_i (indirect_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .req_enter_o(req_enter),
    .req_exit_o (req_exit)
  );

  lcd_ps_wake_cnt #(
    .DIRECT_WR(DIRECT_WR), .INDIRECT_WR(INDIRECT_WR)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q != PS_WAKE),
    .inc_i     (wr_en_i && state_q == PS_WAKE),
    .indirect_i(indirect_i),
    .done_o    (wake_done)
  );

  lcd_ps_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_enter_i(req_enter),
    .req_exit_i (req_exit),
    .frame_i    (frame_i),
    .wake_done_i(wake_done),
    .state_q_o  (state_q),
    .state_d_o  (state_d)
  );

  lcd_ps_pins u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_q_i   (state_q),
    .state_d_i   (state_d),
    .frame_i     (frame_i),
    .blank_o     (blank_o),
    .ydis_o      (ydis_o),
    .clk_en_o    (clk_en_o),
    .panel_hold_o(panel_hold_o),
    .bus_hiz_o   (bus_hiz_o),
    .ready_o     (ready_o)
  );
endmodule

// File: rtl/lcd_ps_checker.sv
module lcd_ps_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic frame_i,
  input logic blank_o,
  input logic ydis_o,
  input logic clk_en_o,
  input logic panel_hold_o,
  input logic bus_hiz_o,
  input logic ready_o
);
  AST_SLEEP_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_hold_o |-> (bus_hiz_o && !clk_en_o && !ready_o)); // R4
  AST_YDIS_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_hold_o |-> !ydis_o); // R5
  AST_ENTRY_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(panel_hold_o) |-> ($past(frame_i) && $past(blank_o))); // R3
  AST_BLANK_KEEPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(blank_o) && !panel_hold_o) |-> ready_o); // R3
  AST_YDIS_FALL_AT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ydis_o) |-> $rose(panel_hold_o)); // R5
  AST_YDIS_RISE_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ydis_o) |-> $past(frame_i)); // R11
  AST_WAKE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(panel_hold_o) |-> (!ready_o && blank_o && clk_en_o && !bus_hiz_o)); // R9
  AST_READY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(wr_en_i) && !blank_o)); // R10
endmodule

bind lcd_pwrsave_seq lcd_ps_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .frame_i     (frame_i),
  .blank_o     (blank_o),
  .ydis_o      (ydis_o),
  .clk_en_o    (clk_en_o),
  .panel_hold_o(panel_hold_o),
  .bus_hiz_o   (bus_hiz_o),
  .ready_o     (ready_o)
);

// File: tb/lcd_pwrsave_seq_test.sv
module lcd_pwrsave_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       indirect = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       frame = 1'b0;
  logic blank, ydis, clk_en, hold, hiz, ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_pwrsave_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .indirect_i(indirect),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .frame_i(frame), .blank_o(blank), .ydis_o(ydis), .clk_en_o(clk_en),
    .panel_hold_o(hold), .bus_hiz_o(hiz), .ready_o(ready)
  );

  // vector order: blank, ydis, clk_en, hold, hiz, ready
  localparam logic [5:0] RUN_V   = 6'b011001;
  localparam logic [5:0] ENTRY_V = 6'b111001;
  localparam logic [5:0] SLEEP_V = 6'b100110;

  function automatic logic [5:0] wake_v(input logic yd);
    return {1'b1, yd, 1'b1, 1'b0, 1'b0, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {blank, ydis, clk_en, hold, hiz, ready};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frm();
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input bit m);
    if (m) wr(4'h1, 8'h53); else wr(4'h8, 8'h01);
  endtask

  task automatic ex(input bit m);
    if (m) wr(4'h1, 8'h40); else wr(4'h8, 8'h00);
  endtask

  // request in the form of the other mode
  task automatic wrong_req(input bit m);
    if (m) wr(4'h8, 8'h01); else wr(4'h1, 8'h53);
  endtask

  task automatic wrong_ex(input bit m);
    if (m) wr(4'h8, 8'h00); else wr(4'h1, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset state", RUN_V);

    for (int m = 0; m < 2; m++) begin
      indirect = m[0];
      idle(1);
      wrong_req(m[0]);
      idle(2);
      chk("R2 other-mode request ignored", RUN_V);
      wr(4'h3, 8'h01);
      chk("R2 unrelated address ignored", RUN_V);
      for (int k = 0; k < 3; k++) begin
        for (int a = 0; a < 3; a++) begin
          int need;
          need = m ? 2 : 1;
          req(m[0]);
          chk("R2 R3 request starts blanking", ENTRY_V);
          req(m[0]);
          chk("R6 repeat request during entry", ENTRY_V);
          idle(k);
          chk("R3 no entry without frame", ENTRY_V);
          if (a == 1) begin
            ex(m[0]);
            chk("R7 abort before first frame", RUN_V);
            frm(); frm();
            chk("R7 frames after abort", RUN_V);
            continue;
          end
          frm();
          chk("R3 R6 still blanking after first frame", ENTRY_V);
          if (a == 2) begin
            ex(m[0]);
            chk("R7 abort in blank frame", RUN_V);
            frm(); frm();
            chk("R7 frames after abort", RUN_V);
            continue;
          end
          idle(k);
          frm();
          chk("R3 R4 R5 asleep after second frame", SLEEP_V);
          frm();
          chk("R8 frame in sleep ignored", SLEEP_V);
          req(m[0]);
          wrong_ex(m[0]);
          wr(4'h3, 8'h00);
          chk("R8 R2 writes in sleep ignored", SLEEP_V);
          ex(m[0]);
          chk("R9 wake-up pins", wake_v(1'b0));
          if (k == 1) begin
            frm();
            chk("R11 ydis lifts before dummy writes", wake_v(1'b1));
          end
          for (int i = 0; i < need; i++) begin
            wr(4'(i + 2), 8'hA5);
            if (i < need - 1)
              chk("R10 ready held before last dummy write", wake_v(k == 1));
            else
              chk("R10 ready after last dummy write",
                  {1'b0, (k == 1) ? 1'b1 : 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
          end
          if (k != 1) begin
            idle(2);
            chk("R11 ydis low until frame", 6'b001001);
            frm();
            chk("R11 ydis lifts on frame", RUN_V);
          end
          idle(1);
          chk("R1 back to running", RUN_V);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule